// File: doc/BRIEF.md
# Multiprocessor Interrupt and Arbitration Register

This block holds one 64-bit register that four processors share. The register carries a per-processor flag for interprocessor interrupts and a per-processor flag for interval timer interrupts, plus two small arbitration fields. Each field has its own write rule: write-one-to-clear, write-one-to-set, set-only-while-empty, or plain read/write. The block also keeps four 25-bit ignore counters, one per processor. These counters thin a shared periodic timer tick, so that each processor takes timer interrupts only after a programmed number of ticks has gone by.

Software reaches the register and the counters through one 64-bit register port. A request carries the index of the issuing processor. Reads of the shared register return that index in the two lowest bits, so each processor can find out which processor it is. The block drives one interprocessor interrupt line and one timer interrupt line for each processor. Both lines come straight from register bits.

Top module: `mpm_misc_irq`

## Requirements
- R1: After reset, address 0 reads 0x0000_0008_0000_0000 with the requester index ORed into bits 1:0, every counter reads 0, and all interrupt outputs are low.
- R2: A write to address 0 clears every stored bit where the write data has a 1 under mask 0x1000_0FF0, which covers the timer flags in bits 7:4 and the interprocessor flags in bits 11:8.
- R3: A write to address 0 with a 1 in bit 12+i sets interprocessor flag bit 8+i. This takes precedence over a clear of the same bit in the same write.
- R4: A write to address 0 with bit 20 set clears bits 23:16. With bit 20 clear, bits 23:20 are write-one-to-set.
- R5: With bit 20 clear, the ones written to bits 19:16 are ORed in only when the stored 19:16 field is all zero. Otherwise that field is left unchanged.
- R6: Bits 43:40 of address 0 are plain read/write. Every other bit that no rule names keeps its value, including the revision bit 35.
- R7: A read of address 0 returns the stored value with the 2-bit requester index in bits 1:0. Those two bits are never stored.
- R8: ipi_irq[i] equals interprocessor flag bit 8+i and changes on the clock edge that accepts the write.
- R9: A write to address 1+i loads counter i with write data bits 23:0 and clears its overflow bit 24. A read of address 1+i returns all 25 counter bits, zero-extended.
- R10: On each rising edge of tick, every counter not being written decrements modulo 2^25, and bit 24 stays set once it is set. A tick held high, and a falling tick, change nothing.
- R11: When a tick rising edge leaves bit 24 of counter i set, timer flag bit 4+i and tmr_irq[i] go high on that edge. A register write can lower tmr_irq[i] but can never raise it.
- R12: When a write to counter i and a tick rising edge fall in the same cycle, the write wins. That counter does not decrement and raises no timer flag in that cycle.
- R13: Addresses 5 to 7 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request valid this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | 0 = shared register, 1..4 = ignore counter 0..3, others unmapped |
| req_cpu | input | 2 | Index of the requesting processor |
| req_wdata | input | 64 | Write data |
| tick | input | 1 | Shared periodic timer tick, synchronous level |
| rdata | output | 64 | Read data, valid in the same cycle as a read request |
| ipi_irq | output | 4 | Interprocessor interrupt, one per processor |
| tmr_irq | output | 4 | Timer interrupt, one per processor |

## Verification
The assertions assume that tick is already synchronous to clk and that every input holds a defined value while rst_n is high. They also assume that a request is a single-cycle pulse whose read data is taken in the same cycle. The bench respects these assumptions. It changes every input only on the falling clock edge and keeps tick low through reset. It produces tick edges only as whole-cycle levels, including one pulse held high for several cycles and one rising edge that lands in the same cycle as a counter write.

// File: rtl/mpm_pkg.sv
// Shared constants for the multiprocessor interrupt register.
// Assumes exactly four processors; the field positions depend on that count.
package mpm_pkg;
    localparam int NCPU      = 4;
    localparam int DATA_W    = 64;
    localparam int IDX_W     = $clog2(NCPU);

    // Bit positions of the shared register fields
    localparam int TMR_LSB   = 4;
    localparam int IPI_LSB   = 8;
    localparam int REQ_LSB   = 12;
    localparam int WON_LSB   = 16;
    localparam int ARB_CLR   = 20;
    localparam int TRY_LSB   = 20;
    localparam int RW_LSB    = 40;
    localparam int FIELD_W   = 4;

    localparam logic [DATA_W-1:0] CLR_MASK  = 64'h0000_0000_1000_0FF0;
    localparam logic [DATA_W-1:0] RESET_VAL = 64'h0000_0008_0000_0000;
endpackage

// File: rtl/mpm_tick_edge.sv
// Rising-edge detector for the shared timer tick.
// Assumes tick is already synchronous to clk; a tick that is high when
// reset ends counts as a rising edge.
module mpm_tick_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic rise
);
    logic tick_q;

    // Remember the previous tick level
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick;
    end

    assign rise = tick & ~tick_q;
endmodule

// File: rtl/mpm_ignore_cnt.sv
// One interval ignore counter. A write loads the low bits and clears the
// sticky overflow bit. A tick rising edge decrements modulo 2^CNT_W and
// keeps the top bit sticky. fire reports a tick that leaves the overflow
// bit set. Assumes wr and tick_rise are single-cycle qualified pulses.
module mpm_ignore_cnt #(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-2:0] load_val,
    input  logic             tick_rise,
    output logic [CNT_W-1:0] cnt_q,
    output logic             fire
);
    localparam int MSB = CNT_W - 1;

    logic [CNT_W-1:0] dec;
    logic [CNT_W-1:0] nxt_dec;

    // Decrement with a sticky overflow bit
    always_comb begin
        dec     = cnt_q - 1'b1;
        nxt_dec = {cnt_q[MSB] | dec[MSB], dec[MSB-1:0]};
    end

    assign fire = tick_rise & ~wr & nxt_dec[MSB];

    // Counter state: a write has priority over a tick
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (wr)        cnt_q <= {1'b0, load_val};
        else if (tick_rise) cnt_q <= nxt_dec;
    end
endmodule

// File: rtl/mpm_misc_reg.sv
// The shared 64-bit register with its per-field write rules.
// Timer flags are set only by fire and cleared only by writes.
// Assumes wr is a qualified single-cycle write strobe.
module mpm_misc_reg
    import mpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NCPU-1:0]   fire,
    output logic [DATA_W-1:0] reg_q
);
    logic [DATA_W-1:0] nxt;

    // Next value: write rules first, then timer flags from the counters
    always_comb begin
        nxt = reg_q;
        if (wr) begin
            nxt = reg_q & ~(wdata & CLR_MASK);
            if (wdata[ARB_CLR]) begin
                nxt[TRY_LSB+:FIELD_W] = '0;
                nxt[WON_LSB+:FIELD_W] = '0;
            end else begin
                nxt[TRY_LSB+:FIELD_W] = nxt[TRY_LSB+:FIELD_W] | wdata[TRY_LSB+:FIELD_W];
                if (reg_q[WON_LSB+:FIELD_W] == '0)
                    nxt[WON_LSB+:FIELD_W] = wdata[WON_LSB+:FIELD_W];
            end
            nxt[IPI_LSB+:NCPU]   = nxt[IPI_LSB+:NCPU] | wdata[REQ_LSB+:NCPU];
            nxt[RW_LSB+:FIELD_W] = wdata[RW_LSB+:FIELD_W];
        end
        nxt[TMR_LSB+:NCPU] = nxt[TMR_LSB+:NCPU] | fire;
    end

    // Register state
    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= RESET_VAL;
        else        reg_q <= nxt;
    end
endmodule

// File: rtl/mpm_misc_irq.sv
// Top: address decode, one ignore counter per processor, the shared
// register and the read mux. Interrupt outputs are register bits.
// Assumes single-cycle requests; read data is combinational.
module mpm_misc_irq
    import mpm_pkg::*;
#(
    parameter int CNT_W  = 25,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [IDX_W-1:0]  req_cpu,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              tick,
    output logic [DATA_W-1:0] rdata,
    output logic [NCPU-1:0]   ipi_irq,
    output logic [NCPU-1:0]   tmr_irq
);
    localparam int LOAD_W   = CNT_W - 1;
    localparam int CNT_BASE = 1;

    logic              tick_rise;
    logic              wr_misc;
    logic [NCPU-1:0]   wr_cnt;
    logic [NCPU-1:0]   fire;
    logic [DATA_W-1:0] misc_q;
    logic [CNT_W-1:0]  cnt_q [NCPU];

    assign wr_misc = req_valid & req_write & (req_addr == '0);

    mpm_tick_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .rise  (tick_rise)
    );

    for (genvar i = 0; i < NCPU; i++) begin : g_cnt
        assign wr_cnt[i] = req_valid & req_write & (req_addr == ADDR_W'(CNT_BASE + i));

        mpm_ignore_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (wr_cnt[i]),
            .load_val  (req_wdata[LOAD_W-1:0]),
            .tick_rise (tick_rise),
            .cnt_q     (cnt_q[i]),
            .fire      (fire[i])
        );
    end

    mpm_misc_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_misc),
        .wdata (req_wdata),
        .fire  (fire),
        .reg_q (misc_q)
    );

    assign ipi_irq = misc_q[IPI_LSB+:NCPU];
    assign tmr_irq = misc_q[TMR_LSB+:NCPU];

    // Read mux: shared register with the requester index, or a counter
    always_comb begin
        rdata = '0;
        if (req_valid && !req_write) begin
            if (req_addr == '0)
                rdata = misc_q | DATA_W'(req_cpu);
            for (int i = 0; i < NCPU; i++)
                if (req_addr == ADDR_W'(CNT_BASE + i))
                    rdata = DATA_W'(cnt_q[i]);
        end
    end
endmodule

// File: rtl/mpm_checker.sv
// Property checker for mpm_misc_irq, attached by bind. Assumes tick is
// synchronous and requests are single-cycle; watches ports only.
module mpm_checker
    import mpm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [2:0]        req_addr,
    input logic [IDX_W-1:0]  req_cpu,
    input logic [DATA_W-1:0] req_wdata,
    input logic              tick,
    input logic [DATA_W-1:0] rdata,
    input logic [NCPU-1:0]   ipi_irq,
    input logic [NCPU-1:0]   tmr_irq
);
    logic tick_d;
    logic wr_misc;
    logic rd_req;

    // Own copy of the previous tick level
    always_ff @(posedge clk) begin
        if (!rst_n) tick_d <= 1'b0;
        else        tick_d <= tick;
    end

    assign wr_misc = req_valid && req_write && (req_addr == 3'd0);
    assign rd_req  = req_valid && !req_write;

    AST_READ_CPU_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr == 3'd0) |-> (rdata[1:0] == req_cpu)) else $error("cpu index"); // R7

    AST_CNT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr >= 3'd1 && req_addr <= 3'd4) |-> (rdata[63:25] == '0)) else $error("counter width"); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr >= 3'd5) |-> (rdata == '0)) else $error("unmapped read"); // R13

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        AST_IPI_RISE_BY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ipi_irq[i]) |-> $past(wr_misc && req_wdata[REQ_LSB+i])) else $error("ipi rise"); // R3

        AST_IPI_FALL_BY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ipi_irq[i]) |-> $past(wr_misc && req_wdata[IPI_LSB+i])) else $error("ipi fall"); // R2

        AST_TMR_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tmr_irq[i]) |-> $past(tick && !tick_d)) else $error("tmr rise"); // R11

        AST_TMR_FALL_BY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(tmr_irq[i]) |-> $past(wr_misc && req_wdata[TMR_LSB+i])) else $error("tmr fall"); // R11
    end
endmodule

bind mpm_misc_irq mpm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_cpu   (req_cpu),
    .req_wdata (req_wdata),
    .tick      (tick),
    .rdata     (rdata),
    .ipi_irq   (ipi_irq),
    .tmr_irq   (tmr_irq)
);

// File: tb/sim_mpm_misc_irq.sv
module sim_mpm_misc_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [1:0]  req_cpu = '0;
    logic [63:0] req_wdata = '0;
    logic        tick = 1'b0;
    logic [63:0] rdata;
    logic [3:0]  ipi_irq;
    logic [3:0]  tmr_irq;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference state
    logic [63:0] m_misc;
    logic [24:0] m_cnt [4];
    logic        m_tick_prev;

    always #4 clk = ~clk;

    mpm_misc_irq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_cpu(req_cpu), .req_wdata(req_wdata),
        .tick(tick), .rdata(rdata), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_read(logic [2:0] a, logic [1:0] c);
        if (a == 3'd0) return m_misc | {62'd0, c};
        if (a <= 3'd4) return {39'd0, m_cnt[a-1]};
        return 64'd0;
    endfunction

    // Reference update for one clock edge, from the held inputs
    task automatic model_clock();
        logic [63:0] v;
        logic [63:0] n;
        bit rise;
        v = req_wdata;
        rise = tick && !m_tick_prev;
        m_tick_prev = tick;
        if (req_valid && req_write && req_addr == 3'd0) begin
            n = m_misc;
            for (int b = 0; b < 64; b++)
                if (((64'h1000_0FF0 >> b) & 64'd1) != 0 && v[b]) n[b] = 1'b0;
            if (v[20]) begin
                for (int b = 16; b < 24; b++) n[b] = 1'b0;
            end else begin
                for (int b = 20; b < 24; b++) if (v[b]) n[b] = 1'b1;
                if (m_misc[19:16] == 4'd0)
                    for (int b = 16; b < 20; b++) if (v[b]) n[b] = 1'b1;
            end
            for (int k = 0; k < 4; k++) if (v[12+k]) n[8+k] = 1'b1;
            for (int b = 40; b < 44; b++) n[b] = v[b];
            m_misc = n;
        end
        for (int k = 0; k < 4; k++) begin
            if (req_valid && req_write && req_addr == 3'(k + 1)) begin
                m_cnt[k] = {1'b0, v[23:0]};
            end else if (rise) begin
                logic sticky;
                sticky = m_cnt[k][24];
                m_cnt[k] = m_cnt[k] - 25'd1;
                if (sticky) m_cnt[k][24] = 1'b1;
                if (m_cnt[k][24]) m_misc[4+k] = 1'b1;
            end
        end
    endtask

    // One clock: drive at the falling edge, check reads, then outputs
    task automatic step(bit v, bit w, logic [2:0] a, logic [1:0] c,
                        logic [63:0] d, bit t, string tag);
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_cpu = c;
        req_wdata = d; tick = t;
        if (v && !w) begin
            #1;
            chk(tag, rdata, model_read(a, c));
        end
        @(posedge clk);
        model_clock();
        #1;
        chk("R8 ipi_irq", {60'd0, ipi_irq}, {60'd0, m_misc[11:8]});
        chk("R11 tmr_irq", {60'd0, tmr_irq}, {60'd0, m_misc[7:4]});
    endtask

    task automatic wr(logic [2:0] a, logic [63:0] d, string tag);
        step(1, 1, a, 2'd0, d, tick, tag);
    endtask

    task automatic rd(logic [2:0] a, logic [1:0] c, string tag);
        step(1, 0, a, c, 64'd0, tick, tag);
    endtask

    task automatic idle(bit t);
        step(0, 0, 3'd0, 2'd0, 64'd0, t, "idle");
    endtask

    // Read with a fixed expected value as well as the model
    task automatic rdx(logic [2:0] a, logic [1:0] c, logic [63:0] exp, string tag);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_cpu = c; req_wdata = '0;
        #1;
        chk(tag, rdata, exp);
        @(posedge clk);
        model_clock();
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        m_misc = 64'h0000_0008_0000_0000;
        for (int k = 0; k < 4; k++) m_cnt[k] = '0;
        m_tick_prev = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R7 requester index, R13 unmapped
        rdx(3'd0, 2'd0, 64'h0000_0008_0000_0000, "R1");
        rdx(3'd0, 2'd3, 64'h0000_0008_0000_0003, "R7");
        for (int k = 1; k <= 4; k++) rdx(3'(k), 2'd1, 64'd0, "R1 counter");
        rdx(3'd5, 2'd0, 64'd0, "R13");
        chk("R1 outputs", {56'd0, ipi_irq, tmr_irq}, 64'd0);

        // R3 request bits raise interprocessor flags
        wr(3'd0, 64'h0000_F000, "R3");
        rdx(3'd0, 2'd1, 64'h0000_0008_0000_0F01, "R3");
        // R2 clear two flags
        wr(3'd0, 64'h0000_0500, "R2");
        rdx(3'd0, 2'd2, 64'h0000_0008_0000_0A02, "R2");
        // R3 set beats clear in the same write
        wr(3'd0, 64'h0000_1100, "R3");
        rd(3'd0, 2'd0, "R3");
        // R4 and R5 arbitration fields
        wr(3'd0, 64'h00A5_0000, "R4");
        rdx(3'd0, 2'd0, 64'h0000_0008_00A5_0B00, "R4");
        wr(3'd0, 64'h0042_0000, "R5");
        rdx(3'd0, 2'd0, 64'h0000_0008_00E5_0B00, "R5");
        wr(3'd0, 64'h0010_0000, "R4");
        rdx(3'd0, 2'd0, 64'h0000_0008_0000_0B00, "R4");
        wr(3'd0, 64'h0003_0000, "R5");
        wr(3'd0, 64'h0004_0000, "R5");
        rdx(3'd0, 2'd0, 64'h0000_0008_0003_0B00, "R5");
        // R6 plain field and untouched bits
        wr(3'd0, 64'h0000_0A00_4000_0000, "R6");
        rdx(3'd0, 2'd0, 64'h0000_0A08_0003_0B00, "R6");
        wr(3'd0, 64'h0000_0000_0000_0000, "R6");
        rd(3'd0, 2'd3, "R6");

        // R9 counter loads
        wr(3'd1, 64'd2, "R9");
        wr(3'd2, 64'hFFFF_FFFF_FF00_0001, "R9");
        wr(3'd3, 64'd5, "R9");
        wr(3'd4, 64'h00FF_FFFF, "R9");
        rdx(3'd2, 2'd0, 64'd1, "R9");
        rdx(3'd4, 2'd0, 64'h00FF_FFFF, "R9");

        // R10 ticks: one pulse held high counts once
        idle(1); idle(1); idle(1); idle(0);
        rd(3'd1, 2'd0, "R10");
        for (int p = 0; p < 3; p++) begin
            idle(1); idle(0);
        end
        rd(3'd1, 2'd0, "R10");
        rd(3'd2, 2'd0, "R10");
        rd(3'd3, 2'd0, "R10");
        rd(3'd4, 2'd0, "R10");
        rd(3'd0, 2'd0, "R11");

        // R11 write clears timer flag 0, cannot set it
        wr(3'd0, 64'h0000_0010, "R11");
        wr(3'd0, 64'h0000_0000, "R11");
        idle(1); idle(0);
        rd(3'd0, 2'd0, "R11");
        wr(3'd0, 64'h0000_0010, "R11");

        // R12 counter write in the same cycle as a tick rise
        step(1, 1, 3'd1, 2'd0, 64'h10, 1, "R12");
        idle(0);
        rdx(3'd1, 2'd0, 64'h10, "R12");
        chk("R12 tmr0", {63'd0, tmr_irq[0]}, 64'd0);

        // R13 unmapped writes change nothing
        wr(3'd6, 64'hFFFF_FFFF_FFFF_FFFF, "R13");
        wr(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, "R13");
        rd(3'd0, 2'd2, "R13");
        rd(3'd1, 2'd0, "R13");
        rd(3'd7, 2'd0, "R13");

        idle(0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule